// File: doc/BRIEF.md
# MDIO Management Master

This block is a station-management master for the two-wire MDC/MDIO bus. It handles both the short-address frame (start code 01) and the extended-address frame (start code 00). Software sees a single 32-bit word. The same word holds the start flag, the frame fields and the 16-bit data, and it also reports busy and ready status. Writing the word with bit 31 set sends one frame. The block shifts out a 32-bit preamble of ones and then the frame fields, most significant bit first. On read frames it releases the data line for the turnaround and captures the PHY's 16 data bits on rising MDC edges. When the frame ends, busy clears and a read's result appears in bits 15:0 of the same word.

An extended-address access takes two frames: an address frame that carries the register number in bits 15:0, then a read, read-with-increment or write frame to the same port and device. The block sends the operation field exactly as written, so advancing the register address on an incrementing read is done by the PHY. The MDC rate is set by a half-period divider input. With a 100 MHz core clock, a divider value of 19 gives the usual 2.5 MHz. A synchronous soft reset aborts any frame in progress and clears the data field, so a read never returns a value left over from an earlier frame.

Top module: `mdio_master`

## Requirements
- R1: After rst_n or a one-cycle soft_rst, cmd_rdata reads 32'h4000_0000 (busy 0, ready 1, every field 0), mdc is low and mdio_oe is low, even if a frame was in progress.
- R2: A write with cmd_wdata[31]=1 while idle starts a frame. During the frame cmd_rdata[31]=1 and cmd_rdata[30]=0. When the frame ends both bits return to 0 and 1.
- R3: Every frame is 64 MDC cycles, sent MSB first: 32 ones, then the start code from bits 17:16, the operation from bits 19:18, the port address from bits 24:20 and the register/device address from bits 29:25.
- R4: When bit 19 is 0 (write or address frame), the last 18 bits are the turnaround 1,0 followed by bits 15:0, and mdio_oe is high for all 64 bits.
- R5: When bit 19 is 1 (read or read-with-increment), mdio_oe is low for the last 18 bits. mdio_i is sampled at rising MDC in bits 48..63, and the 16 samples (first sample is MSB) appear in cmd_rdata[15:0] once busy clears.
- R6: The read result depends only on the current frame's samples. With no PHY driving and the line pulled high, the result is 16'hFFFF, not the previous read value.
- R7: A command write while busy is ignored: the frame in flight and the stored fields are unchanged.
- R8: Each MDC half-period lasts div_half+1 clock cycles, so busy stays high for exactly 128*(div_half+1) cycles. mdc is low while idle.
- R9: mdio_o changes only while mdc is low. It is stable across every high phase of mdc.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous reset; aborts a frame and clears the data field |
| div_half | input | DIV_W | MDC half-period minus one, in clock cycles |
| cmd_we | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 32 | Command word to write |
| cmd_rdata | output | 32 | Command/status word readback |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
The bench records every MDC rising edge as a PHY would. It compares the whole frame and the enable pattern bit by bit, so a field in the wrong place, a missing turnaround 1,0 or an enable still high on read data shows up as a bit mismatch. A read from an absent PHY straight after a real read must return all ones; a design that keeps the old sample register would return the earlier value. A second command sent mid-frame must leave the frame and the fields unchanged, and a soft reset partway through a read must drop busy and zero the data. Frame length is counted in clock cycles at several divider values, which catches an off-by-one in the half-period count.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;   // preamble + ST + OP + PHY + REG + TA + DATA
  localparam int TA_START   = 46;   // first turnaround bit index
  localparam int DATA_START = 48;   // first data bit index
  localparam int IDX_W      = $clog2(FRAME_BITS);

  typedef struct packed {
    logic load;     // accepted start command
    logic shift;    // advance to next bit (MDC falling)
    logic capture;  // sample mdio_i (MDC rising, read data phase)
    logic done;     // last bit finished
  } mdioStrb_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             softRst,
  input  logic             cmdWe,
  input  logic             startReq,
  input  logic             isRead,
  input  logic [DIV_W-1:0] divHalf,
  output logic             busy,
  output logic             mdc,
  output logic             oeDrive,
  output mdioStrb_t        strb
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

  logic [DIV_W-1:0] divCnt;
  logic [IDX_W-1:0] bitIdx;
  logic tick, rise, fall, lastBit;

  always_comb begin
    tick         = busy && (divCnt == divHalf);
    rise         = tick && !mdc;
    fall         = tick && mdc;
    lastBit      = (bitIdx == LAST_IDX);
    strb.load    = cmdWe && startReq && !busy;
    strb.shift   = fall && !lastBit;
    strb.done    = fall && lastBit;
    strb.capture = rise && isRead && (bitIdx >= IDX_W'(DATA_START));
    oeDrive      = busy && !(isRead && (bitIdx >= IDX_W'(TA_START)));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      mdc    <= 1'b0;
      divCnt <= '0;
      bitIdx <= '0;
    end else if (softRst) begin
      busy   <= 1'b0;
      mdc    <= 1'b0;
      divCnt <= '0;
      bitIdx <= '0;
    end else if (strb.load) begin
      busy   <= 1'b1;
      mdc    <= 1'b0;
      divCnt <= '0;
      bitIdx <= '0;
    end else if (busy) begin
      if (tick) begin
        divCnt <= '0;
        mdc    <= !mdc;
        if (strb.shift) bitIdx <= bitIdx + 1'b1;
        if (strb.done)  busy   <= 1'b0;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  // R8: clock parked low whenever no frame is running
  assert_mdc_idle_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdc);
  // R2: completion drops busy on the next cycle
  assert_done_clears_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.done && !softRst) |=> (!busy && !mdc));
  // R1: soft reset returns control to idle
  assert_soft_reset_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (!busy && !mdc));
endmodule

// File: rtl/mdio_datapath.sv
module mdio_datapath
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        softRst,
  input  logic        busy,
  input  logic        cmdWe,
  input  logic [31:0] cmdWdata,
  input  mdioStrb_t   strb,
  input  logic        mdioI,
  output logic        isRead,
  output logic        mdioO,
  output logic [31:0] cmdRdata
);
  logic [29:0]           cmdReg;
  logic [FRAME_BITS-1:0] txShift;
  logic [15:0]           rdShift;
  logic                  accept;

  always_comb begin
    accept   = cmdWe && !busy;
    isRead   = cmdReg[19];
    mdioO    = busy ? txShift[FRAME_BITS-1] : 1'b1;
    cmdRdata = {busy, !busy, cmdReg};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg  <= '0;
      txShift <= '1;
      rdShift <= '0;
    end else if (softRst) begin
      cmdReg  <= '0;
      txShift <= '1;
      rdShift <= '0;
    end else begin
      if (accept) cmdReg <= cmdWdata[29:0];
      if (strb.load) begin
        txShift <= {32'hFFFF_FFFF, cmdWdata[17:16], cmdWdata[19:18],
                    cmdWdata[24:20], cmdWdata[29:25], 2'b10, cmdWdata[15:0]};
        rdShift <= '0;
      end else if (strb.shift) begin
        txShift <= {txShift[FRAME_BITS-2:0], 1'b1};
      end
      if (strb.capture) rdShift <= {rdShift[14:0], mdioI};
      if (strb.done && isRead) cmdReg[15:0] <= rdShift;
    end
  end

  // R7: a write during a frame leaves the stored fields alone
  assert_busy_write_ignored_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cmdWe && !softRst) |=> $stable(cmdReg[29:16]));
  // R1: soft reset wipes the data field
  assert_soft_reset_clears_data_R1: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (cmdRdata[15:0] == 16'h0));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic [DIV_W-1:0] div_half,
  input  logic             cmd_we,
  input  logic [31:0]      cmd_wdata,
  output logic [31:0]      cmd_rdata,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);
  mdioStrb_t strb;
  logic      busy, isRead;

  mdio_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rst_n), .softRst(soft_rst), .cmdWe(cmd_we),
    .startReq(cmd_wdata[31]), .isRead(isRead), .divHalf(div_half),
    .busy(busy), .mdc(mdc), .oeDrive(mdio_oe), .strb(strb)
  );

  mdio_datapath u_dp (
    .clk(clk), .rstN(rst_n), .softRst(soft_rst), .busy(busy),
    .cmdWe(cmd_we), .cmdWdata(cmd_wdata), .strb(strb), .mdioI(mdio_i),
    .isRead(isRead), .mdioO(mdio_o), .cmdRdata(cmd_rdata)
  );

  // R9: the data line holds steady while MDC is high
  assert_mdio_stable_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> $stable(mdio_o));
  // R5: the master never drives while sampling read data
  assert_released_on_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strb.capture |-> !mdio_oe);
endmodule

// File: tb/sim_mdio_master.sv
`timescale 1ns/1ps
module sim_mdio_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic [7:0]  div_half = 8'd0;
  logic        cmd_we = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic [31:0] cmd_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  mdio_master #(.DIV_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .div_half(div_half),
    .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  function automatic logic [31:0] mkCmd(input logic [1:0] st, input logic [1:0] op,
                                        input logic [4:0] phy, input logic [4:0] rd,
                                        input logic [15:0] dat);
    return {1'b1, 1'b0, rd, phy, op, st, dat};
  endfunction

  // {command, phy response, divider}
  localparam int NVEC = 6;
  localparam logic [55:0] VEC [NVEC] = '{
    {mkCmd(2'd1, 2'd1, 5'd3,  5'd4,  16'hA5C3), 16'h0000, 8'd0}, // short write
    {mkCmd(2'd1, 2'd2, 5'h1F, 5'd2,  16'h0000), 16'h7500, 8'd1}, // short read
    {mkCmd(2'd0, 2'd0, 5'd5,  5'h1E, 16'h1234), 16'h0000, 8'd0}, // ext address
    {mkCmd(2'd0, 2'd3, 5'd5,  5'h1E, 16'h0000), 16'hBEEF, 8'd2}, // ext read
    {mkCmd(2'd0, 2'd2, 5'd5,  5'h1E, 16'h0000), 16'h0001, 8'd0}, // ext read incr
    {mkCmd(2'd0, 2'd1, 5'd0,  5'd7,  16'hFFFF), 16'h0000, 8'd3}  // ext write
  };

  // PHY-side observer: records bits at MDC rise, drives read data after MDC fall
  logic [63:0] rxBits, oeBits;
  logic [15:0] respVal = '0;
  logic        phyOn = 1'b0;
  logic        mdcPrev = 1'b0;
  int          k = 0;

  always @(negedge clk) begin
    if (!cmd_rdata[31]) k = 0;
    if (mdc && !mdcPrev) begin
      rxBits = {rxBits[62:0], mdio_o};
      oeBits = {oeBits[62:0], mdio_oe};
      k = k + 1;
    end else if (!mdc && mdcPrev) begin
      if (k >= 48 && k <= 63) mdio_i = phyOn ? respVal[63-k] : 1'b1;
      else                    mdio_i = 1'b1;
    end
    mdcPrev = mdc;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic startCmd(input logic [31:0] cmd);
    @(negedge clk);
    cmd_we = 1'b1; cmd_wdata = cmd;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic waitIdle(output int n);
    n = 0;
    while (cmd_rdata[31] && n < 20000) begin
      @(negedge clk);
      n++;
    end
  endtask

  function automatic logic [63:0] expFrame(input logic [31:0] c);
    return {32'hFFFF_FFFF, c[17:16], c[19:18], c[24:20], c[29:25], 2'b10, c[15:0]};
  endfunction

  task automatic checkFrame(input logic [31:0] c, input logic [15:0] rsp, input bit on,
                            input logic [7:0] dv, input int n, input string tag);
    logic [63:0] ef, eo;
    logic [31:0] er;
    logic [15:0] rdv;
    ef = expFrame(c);
    rdv = on ? rsp : 16'hFFFF;
    if (c[19]) begin
      eo = {{46{1'b1}}, 18'h0};
      er = {2'b01, c[29:16], rdv};
      check(rxBits[63:18] == ef[63:18], {"R3 read header ", tag},
            rxBits, ef);
      check(oeBits == eo, {"R5 read enable ", tag}, oeBits, eo);
      check(cmd_rdata == er, {"R5 R6 read result ", tag}, cmd_rdata, er);
    end else begin
      eo = '1;
      er = {2'b01, c[29:0]};
      check(rxBits == ef, {"R3 R4 frame bits ", tag}, rxBits, ef);
      check(oeBits == eo, {"R4 enable ", tag}, oeBits, eo);
      check(cmd_rdata == er, {"R2 status after ", tag}, cmd_rdata, er);
    end
    check(n == 128 * (int'(dv) + 1), {"R8 frame length ", tag}, 64'(n),
          64'(128 * (int'(dv) + 1)));
  endtask

  initial begin : watchdog
    #1_500_000;
    nFails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    int n;
    logic [31:0] c, cOther;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(cmd_rdata == 32'h4000_0000, "R1 reset word", cmd_rdata, 32'h4000_0000);
    check({mdc, mdio_oe} == 2'b00, "R1 reset pins", {mdc, mdio_oe}, 0);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      c = VEC[i][55:24];
      respVal = VEC[i][23:8];
      div_half = VEC[i][7:0];
      phyOn = 1'b1;
      startCmd(c);
      check(cmd_rdata[31:30] == 2'b10, "R2 busy during frame", cmd_rdata[31:30], 2'b10);
      waitIdle(n);
      @(negedge clk);
      checkFrame(c, respVal, 1'b1, div_half, n, $sformatf("vec%0d", i));
    end

    // R6: read from absent PHY right after a real read
    div_half = 8'd0;
    respVal = 16'h7500; phyOn = 1'b1;
    c = mkCmd(2'd1, 2'd2, 5'h1F, 5'd2, 16'h0);
    startCmd(c); waitIdle(n); @(negedge clk);
    checkFrame(c, 16'h7500, 1'b1, 8'd0, n, "R6 present");
    phyOn = 1'b0;
    c = mkCmd(2'd1, 2'd2, 5'd0, 5'd2, 16'h0);
    startCmd(c); waitIdle(n); @(negedge clk);
    checkFrame(c, 16'h0, 1'b0, 8'd0, n, "R6 absent");

    // R7: command written mid-frame is ignored
    phyOn = 1'b1;
    div_half = 8'd1;
    c = mkCmd(2'd1, 2'd1, 5'd9, 5'd17, 16'h3C5A);
    cOther = mkCmd(2'd0, 2'd3, 5'd22, 5'd1, 16'hFFFF);
    startCmd(c);
    repeat (40) @(negedge clk);
    cmd_we = 1'b1; cmd_wdata = cOther;
    @(negedge clk);
    cmd_we = 1'b0;
    waitIdle(n); @(negedge clk);
    check(rxBits == expFrame(c), "R7 frame unchanged", rxBits, expFrame(c));
    check(cmd_rdata == {2'b01, c[29:0]}, "R7 fields unchanged", cmd_rdata,
          {2'b01, c[29:0]});

    // R1: soft reset during a read
    div_half = 8'd0;
    respVal = 16'h7500;
    c = mkCmd(2'd1, 2'd2, 5'h1F, 5'd2, 16'hABCD);
    startCmd(c);
    repeat (110) @(negedge clk);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    check(cmd_rdata == 32'h4000_0000, "R1 soft reset word", cmd_rdata, 32'h4000_0000);
    check({mdc, mdio_oe, mdio_o} == 3'b001, "R1 soft reset pins",
          {mdc, mdio_oe, mdio_o}, 3'b001);

    // R8: slow divider at nominal rate
    div_half = 8'd19;
    c = mkCmd(2'd1, 2'd1, 5'd1, 5'd0, 16'h8001);
    startCmd(c); waitIdle(n); @(negedge clk);
    checkFrame(c, 16'h0, 1'b1, 8'd19, n, "R8 nominal");

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule